// File: doc/BRIEF.md
# Reset Line Controller with Domain-Tracked Status

This block drives a bank of active-high reset lines, 128 by default, into separate clock domains. Software requests a state for each line by writing a bit in one of four 32-bit request words. Each line passes through its own two-stage synchronizer. That synchronizer advances only while the line's clock-enable input is high. Its output is both the reset delivered to the domain and the source of the line's status bit.

Status is read from four further 32-bit words. For most lines a status bit of 1 means the domain has left reset. A fixed set of lines, chosen by a parameter mask, reports the opposite way. The mask is equal to the status pattern seen when every line is held in reset. A line whose domain clock is gated keeps its status unchanged, so software polling for completion of a deassert can wait indefinitely. A 64-bit access is made as two 32-bit accesses to a word pair, low half first. The pair flag on the bus makes that access atomic: paired writes commit both halves together, and paired reads return a snapshot of the high half taken at the low read.

Top module: `rstline_ctrl`

## Requirements
- R1: After the controller reset is released, every request bit reads 1, every line_rst bit is 1, and each status word reads the matching 32-bit slice of the polarity mask.
- R2: Byte offset 4*m (m = 0..3) selects request word m, and bit n of it drives line 32*m+n, where 1 requests reset. Address bits [1:0] are ignored. With its enable high, line_rst[i] takes the new request value on the second rising clock edge after the write edge.
- R3: A read of a request word returns the last value committed to it. Read data appears with bus_rvalid one cycle after the request. When no read was made, bus_rdata is zero and bus_rvalid is low.
- R4: Status word m sits at offset 0x10+4*m. A status bit equals the inverse of line_rst for a normal line, and equals line_rst for a line whose bit is set in the mask. The default mask is 128'h00000000_00000040_00000300_00000061.
- R5: While line_clk_en[i] is low, line_rst[i] and its status bit hold their value, whatever the request bit does.
- R6: Writes to status offsets change nothing. Reads of offsets 0x20 to 0x3F return zero.
- R7: A paired write to an even request word (offsets 0x00 and 0x08) is staged and has no effect. It commits in the same cycle as a paired write to the odd partner word, but only if that write is the next bus access.
- R8: A staged half is dropped if any other bus access comes first. A paired write to an odd word with no matching staged half acts as a plain write.
- R9: A paired read of an even word captures the odd partner word. A paired read of that partner, if it is the next bus access, returns the captured value instead of the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_pair | input | 1 | Access is one half of a 64-bit pair |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| line_clk_en | input | 128 | Per-line target clock enable |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| line_rst | output | 128 | Per-line active-high reset to each domain |

## Verification
Two things can happen in the same cycle: a status read, or a paired snapshot, and a synchronizer step that changes the bit being read, because an enable toggles or a request settles. The bench triggers this by polling status words and splitting paired reads around recent request writes, while a random stream toggles enables and mixes accesses every cycle. A behavioural model is compared on every clock. It expects the value from before the edge in read data and snapshots, and the new value on line_rst after the edge.

// File: rtl/rstline_pkg.sv
package rstline_pkg;
  localparam int REG_W = 32;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/rstline_rst_sync.sv
module rstline_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/rstline_line_sync.sv
module rstline_line_sync #(
  parameter int NUM_LINES = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] clk_en,
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] rst_out
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic s1_q, s2_q, s1_d, s2_d;

    always_comb begin
      s1_d = s1_q;
      s2_d = s2_q;
      if (clk_en[i]) begin
        s1_d = req[i];
        s2_d = s1_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= s1_d;
        s2_q <= s2_d;
      end
    end

    assign rst_out[i] = s2_q;

    // R5: a gated domain never sees its reset change
    a_r5_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en[i] |=> $stable(rst_out[i]));
  end
endmodule

// File: rtl/rstline_regfile.sv
module rstline_regfile
  import rstline_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_pair,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  word_t                bus_wdata,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] req_o,
  output word_t                bus_rdata,
  output logic                 bus_rvalid
);
  localparam int NUM_REGS = NUM_LINES / REG_W;
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int WIDX_W   = ADDR_W - 2;

  logic [WIDX_W-1:0] w;
  logic [IDX_W-1:0]  idx, pidx;
  logic              mapped, is_status, hi, bank_req, wr_go, rd_go;
  logic              pair_commit, use_snap;
  word_t             rd_word, part_word;
  logic              unused_lowaddr;

  logic [NUM_LINES-1:0] req_q, req_d;
  logic                 stg_vld_q, stg_vld_d;
  logic [IDX_W-1:0]     stg_idx_q, stg_idx_d;
  word_t                stg_data_q, stg_data_d;
  logic                 snap_vld_q, snap_vld_d;
  logic [WIDX_W-1:0]    snap_w_q, snap_w_d;
  word_t                snap_data_q, snap_data_d;
  word_t                rdata_q, rdata_d;
  logic                 rvalid_q, rvalid_d;

  // decode
  assign unused_lowaddr = ^bus_addr[1:0];
  assign w         = bus_addr[ADDR_W-1:2];
  assign mapped    = (w[WIDX_W-1:IDX_W+1] == '0);
  assign is_status = w[IDX_W];
  assign idx       = w[IDX_W-1:0];
  assign pidx      = idx | IDX_W'(1);
  assign hi        = idx[0];
  assign bank_req  = mapped & ~is_status;
  assign wr_go     = bus_sel & bus_wr;
  assign rd_go     = bus_sel & ~bus_wr;

  assign rd_word   = !mapped   ? '0 :
                     is_status ? status_i[idx*REG_W +: REG_W] : req_q[idx*REG_W +: REG_W];
  assign part_word = is_status ? status_i[pidx*REG_W +: REG_W] : req_q[pidx*REG_W +: REG_W];

  assign pair_commit = bus_pair & hi & stg_vld_q & (stg_idx_q == (idx ^ IDX_W'(1)));
  assign use_snap    = bus_pair & mapped & hi & snap_vld_q & (snap_w_q == (w ^ WIDX_W'(1)));

  always_comb begin
    req_d       = req_q;
    stg_vld_d   = stg_vld_q;
    stg_idx_d   = stg_idx_q;
    stg_data_d  = stg_data_q;
    snap_vld_d  = snap_vld_q;
    snap_w_d    = snap_w_q;
    snap_data_d = snap_data_q;
    rvalid_d    = 1'b0;
    rdata_d     = '0;
    if (bus_sel) begin
      stg_vld_d  = 1'b0;
      snap_vld_d = 1'b0;
    end
    if (wr_go && bank_req) begin
      if (bus_pair && !hi) begin
        stg_vld_d  = 1'b1;
        stg_idx_d  = idx;
        stg_data_d = bus_wdata;
      end else begin
        req_d[idx*REG_W +: REG_W] = bus_wdata;
        if (pair_commit) req_d[stg_idx_q*REG_W +: REG_W] = stg_data_q;
      end
    end
    if (rd_go) begin
      rvalid_d = 1'b1;
      rdata_d  = use_snap ? snap_data_q : rd_word;
      if (bus_pair && mapped && !hi) begin
        snap_vld_d  = 1'b1;
        snap_w_d    = w;
        snap_data_d = part_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= '1;
      stg_vld_q   <= 1'b0;
      stg_idx_q   <= '0;
      stg_data_q  <= '0;
      snap_vld_q  <= 1'b0;
      snap_w_q    <= '0;
      snap_data_q <= '0;
      rdata_q     <= '0;
      rvalid_q    <= 1'b0;
    end else begin
      req_q       <= req_d;
      stg_vld_q   <= stg_vld_d;
      stg_idx_q   <= stg_idx_d;
      stg_data_q  <= stg_data_d;
      snap_vld_q  <= snap_vld_d;
      snap_w_q    <= snap_w_d;
      snap_data_q <= snap_data_d;
      rdata_q     <= rdata_d;
      rvalid_q    <= rvalid_d;
    end
  end

  assign req_o      = req_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R6: status offsets are read-only
  a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && mapped && is_status) |=> $stable(req_o));
  // R7: a staged low half leaves the request bank untouched
  a_r7_stage_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && bus_pair && bank_req && !hi) |=> $stable(req_o));
  // R3: read response timing and idle value
  a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> bus_rvalid);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> (!bus_rvalid && bus_rdata == '0));
  // R6: unmapped reads return zero
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !mapped) |=> (bus_rdata == '0));
endmodule

// File: rtl/rstline_ctrl.sv
module rstline_ctrl
  import rstline_pkg::*;
#(
  parameter int                     NUM_LINES   = 128,
  parameter int                     ADDR_W      = 6,
  parameter logic [NUM_LINES-1:0]   DIRECT_MASK = 128'h00000000_00000040_00000300_00000061
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic                 bus_pair,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  input  logic [NUM_LINES-1:0] line_clk_en,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_LINES-1:0] line_rst
);
  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] req;
  logic [NUM_LINES-1:0] status;

  rstline_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  rstline_regfile #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regfile (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_pair   (bus_pair),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status_i   (status),
    .req_o      (req),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  rstline_line_sync #(
    .NUM_LINES (NUM_LINES)
  ) u_line_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clk_en  (line_clk_en),
    .req     (req),
    .rst_out (line_rst)
  );

  // mixed polarity: all-asserted status equals DIRECT_MASK
  assign status = ~line_rst ^ DIRECT_MASK;

  // R1: every line is held in reset when the controller leaves reset
  a_r1_release_asserted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (&line_rst));
endmodule

// File: tb/rstline_ctrl_bench.sv
module rstline_ctrl_bench;
  localparam logic [127:0] DMASK = 128'h00000000_00000040_00000300_00000061;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         bus_sel = 1'b0, bus_wr = 1'b0, bus_pair = 1'b0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [127:0] line_clk_en = '1;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [127:0] line_rst;

  int    vectors = 0;
  int    fails = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  rstline_ctrl u_rstline_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_pair(bus_pair), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .line_clk_en(line_clk_en), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .line_rst(line_rst)
  );

  // ---------------- behavioural reference model ----------------
  bit [127:0] m_req = '1, m_s1 = '1, m_s2 = '1;
  bit         m_stg_v = 0, m_snap_v = 0, m_rv = 0;
  int         m_stg_i = 0, m_snap_w = 0, rcnt = 0;
  bit [31:0]  m_stg_d = 0, m_snap_d = 0, m_rdata = 0;

  function automatic bit [31:0] m_stat(int k);
    return (~m_s2[k*32 +: 32]) ^ DMASK[k*32 +: 32];
  endfunction

  task automatic m_clear();
    m_req = '1; m_s1 = '1; m_s2 = '1;
    m_stg_v = 0; m_snap_v = 0; m_rv = 0; m_rdata = 0;
  endtask

  task automatic m_step();
    int w, ix;
    bit mapped, st, hi, old_stg_v, old_snap_v;
    bit [31:0] live, part;
    bit [127:0] n1, n2;
    w = int'(bus_addr[5:2]);
    mapped = (w < 8); st = (w >= 4) && mapped; ix = w % 4; hi = (ix % 2) == 1;
    live = !mapped ? 32'h0 : (st ? m_stat(ix) : m_req[ix*32 +: 32]);
    part = st ? m_stat(ix | 1) : m_req[(ix | 1)*32 +: 32];
    n1 = (line_clk_en & m_req) | (~line_clk_en & m_s1);
    n2 = (line_clk_en & m_s1)  | (~line_clk_en & m_s2);
    old_stg_v = m_stg_v; old_snap_v = m_snap_v;
    m_rv = 0; m_rdata = 0;
    if (bus_sel) begin
      m_stg_v = 0; m_snap_v = 0;
      if (bus_wr) begin
        if (mapped && !st) begin
          if (bus_pair && !hi) begin
            m_stg_v = 1; m_stg_i = ix; m_stg_d = bus_wdata;
          end else begin
            if (bus_pair && hi && old_stg_v && m_stg_i == ix - 1)
              m_req[m_stg_i*32 +: 32] = m_stg_d;
            m_req[ix*32 +: 32] = bus_wdata;
          end
        end
      end else begin
        m_rv = 1;
        m_rdata = (bus_pair && mapped && hi && old_snap_v && m_snap_w == w - 1) ? m_snap_d : live;
        if (bus_pair && mapped && !hi) begin
          m_snap_v = 1; m_snap_w = w; m_snap_d = part;
        end
      end
    end
    m_s1 = n1; m_s2 = n2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rcnt = 0; m_clear(); end
    else if (rcnt < 2) begin rcnt++; m_clear(); end
    else m_step();
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      vectors++;
      if (line_rst !== m_s2) begin
        fails++;
        $display("FAIL %s line_rst got %h exp %h", tag, line_rst, m_s2);
      end
      if (bus_rvalid !== m_rv || bus_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s read got %b/%h exp %b/%h", tag, bus_rvalid, bus_rdata, m_rv, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string t);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", t, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic p, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_pair = p; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_pair = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic p, input logic [31:0] exp, input string t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_pair = p; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_pair = 0;
    chk(bus_rdata, exp, t);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lf;
    #2 rst_n = 0;
    cmp_on = 1;
    idle(3);
    rst_n = 1;
    idle(4);

    tag = "R1";
    chk(line_rst[31:0] & line_rst[63:32] & line_rst[95:64] & line_rst[127:96], 32'hFFFFFFFF, "R1 lines");
    rd_chk(6'h00, 0, 32'hFFFFFFFF, "R1 req0");
    rd_chk(6'h0C, 0, 32'hFFFFFFFF, "R1 req3");
    rd_chk(6'h10, 0, 32'h00000061, "R1 stat0");
    rd_chk(6'h14, 0, 32'h00000300, "R1 stat1");
    rd_chk(6'h1C, 0, 32'h00000000, "R1 stat3");

    tag = "R2";
    wr(6'h08, 0, 32'hFFFF0000);
    wr(6'h01, 0, 32'h00000000);
    idle(4);
    chk(line_rst[95:64], 32'hFFFF0000, "R2 word2");
    chk(line_rst[31:0], 32'h00000000, "R2 word0");
    tag = "R3";
    rd_chk(6'h08, 0, 32'hFFFF0000, "R3 readback");
    tag = "R4";
    rd_chk(6'h18, 0, 32'h0000FFBF, "R4 stat2");
    rd_chk(6'h10, 0, 32'hFFFFFF9E, "R4 stat0");

    tag = "R5";
    line_clk_en[64] = 0; line_clk_en[65] = 0;
    wr(6'h08, 0, 32'h00000003);
    idle(4);
    chk(line_rst[95:64], 32'h00000000, "R5 gated hold");
    rd_chk(6'h18, 0, 32'hFFFFFFBF, "R5 gated status");
    line_clk_en[64] = 1;
    idle(4);
    chk(line_rst[95:64], 32'h00000001, "R5 one ungated");
    line_clk_en = '1;
    idle(4);
    chk(line_rst[95:64], 32'h00000003, "R5 all ungated");

    tag = "R6";
    wr(6'h10, 0, 32'h12345678);
    idle(2);
    rd_chk(6'h10, 0, 32'hFFFFFF9E, "R6 status write ignored");
    rd_chk(6'h00, 0, 32'h00000000, "R6 req0 intact");
    rd_chk(6'h20, 0, 32'h00000000, "R6 unmapped 0x20");
    rd_chk(6'h3C, 0, 32'h00000000, "R6 unmapped 0x3C");

    tag = "R7";
    wr(6'h08, 1, 32'hA5A50000);
    idle(3);
    chk(line_rst[95:64], 32'h00000003, "R7 staged no effect");
    wr(6'h0C, 1, 32'h000000FF);
    idle(4);
    chk(line_rst[95:64], 32'hA5A50000, "R7 low committed");
    chk(line_rst[127:96], 32'h000000FF, "R7 high committed");
    rd_chk(6'h0C, 0, 32'h000000FF, "R7 readback");

    tag = "R8";
    wr(6'h00, 1, 32'h0000FFFF);
    rd_chk(6'h14, 0, 32'h00000300, "R8 intervening read");
    wr(6'h04, 1, 32'h0F0F0F0F);
    idle(4);
    rd_chk(6'h00, 0, 32'h00000000, "R8 stage dropped");
    rd_chk(6'h04, 0, 32'h0F0F0F0F, "R8 high as plain");

    tag = "R9";
    wr(6'h04, 0, 32'h00000000);
    rd_chk(6'h10, 1, 32'hFFFFFF9E, "R9 low half");
    idle(2);
    rd_chk(6'h14, 1, 32'hF0F0F3F0, "R9 snapshot");
    rd_chk(6'h14, 0, 32'hFFFFFCFF, "R9 live after");

    // mixed stream: reads, paired halves and enable toggles every cycle
    tag = "R5";
    lf = 32'hACE1_2468;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      bus_sel   = lf[0] | lf[7];
      bus_wr    = lf[1] & lf[9];
      bus_pair  = lf[2];
      bus_addr  = {lf[11] & lf[12], lf[8:4]};
      bus_wdata = {lf[15:0], lf[31:16]};
      if (lf[20]) line_clk_en[int'(lf[27:21])] = ~line_clk_en[int'(lf[27:21])];
      if (k == 2500) line_clk_en = '1;
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_pair = 0;
    idle(4);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule